// File: doc/BRIEF.md
# Hybrid Lookahead Carry-Skip Adder

This block adds two 56-bit operands and a carry-in. It returns a 56-bit sum and a carry-out. The operand range fits double-precision mantissa addition. The width is split into groups of 16 bits, and the last group takes whatever width remains. A lookahead chain computes a group generate and a group propagate for each group. From these it delivers a carry into every group boundary, so no group waits on the ripple of the group below it.

Inside each group the carry is formed by a carry-skip adder built from 4-bit ripple sub-blocks. Each sub-block above the lowest one has a multiplexer driven by an active-low skip signal. When every bit from the group's first bit up to the sub-block propagates, the multiplexer takes the group carry-in directly. Otherwise it takes the carry rippled out of the sub-block just below. Each sub-block's skip multiplexer reaches straight back to its own group carry-in. No skip carry is handed from one sub-block to the next.

The adder itself is combinational. An optional output register, on by default, captures sum and carry-out so that the path can be timed between flops.

Top module: `hybrid_skip_adder`

## Requirements
- R1: `{cout, sum}` equals the 57-bit value `a + b + cin`. `cout` is the carry out of bit 55.
- R2: The carry into each group is set at bits 0, 16, 32 and 48. It equals the true carry into that bit position of `a + b + cin`, formed as G + P·c from the group below.
- R3: When a sub-block's active-low skip signal is 0, its carry-in equals the carry-in of its group. The skip signal is 0 exactly when `a ^ b` is 1 at every bit from the group's first bit up to the bit just below the sub-block.
- R4: Every 4-bit sub-block receives the true carry into its lowest bit, whether that carry arrives over the skip path or the ripple path.
- R5: The lowest sub-block of each group takes the group carry-in directly. A carry produced just below a group boundary (bit 15, 31 or 47) appears correctly in the upper group's sum.
- R6: With the output register enabled, `sum` and `cout` show the result of the inputs present at the previous rising clock edge. They stay unchanged between edges.
- R7: While `rst_n` is 0, `sum` and `cout` are held at 0. This is an asynchronous, active-low reset.
- R8: With every bit propagating (`a ^ b` all ones), the result is all ones with `cout` 0 when `cin` is 0. It is all zeros with `cout` 1 when `cin` is 1.
- R9: With every bit generating (`a` and `b` all ones), `cout` is 1 and `sum` is all ones except bit 0, which equals `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | 56 | First operand |
| b | input | 56 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 56 | Sum bits |
| cout | output | 1 | Carry out of bit 55 |

## Verification
The lookahead boundary carry and a sub-block's skip multiplexer can both act on the same carry in the same cycle. This happens when a generate just below a group boundary must cross the boundary through the chain and then jump over a whole propagating group through the skip multiplexers. The bench provokes this case by placing a generate at bit 15 under a fully propagating upper range. It also sweeps a single carry across every sub-block and group boundary, and adds random operands biased toward long propagate runs. Every case is judged by comparing the registered sum and carry-out with a 57-bit addition computed in the bench.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    // Number of lookahead groups needed to cover a given width.
    function automatic int group_count(input int width, input int grp_w);
        return (width + grp_w - 1) / grp_w;
    endfunction

    // Width of group k; the last group takes what remains.
    function automatic int group_width(input int k, input int width, input int grp_w);
        int rest;
        rest = width - k * grp_w;
        return (rest < grp_w) ? rest : grp_w;
    endfunction

endpackage

// File: rtl/hsa_pg_gen.sv
module hsa_pg_gen #(
    parameter int W = 56
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p,
    output logic [W-1:0] g
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign p[i] = a[i] ^ b[i];
        assign g[i] = a[i] & b[i];
    end

endmodule

// File: rtl/hsa_lookahead.sv
module hsa_lookahead #(
    parameter int W     = 56,
    parameter int GRP_W = 16
) (
    input  logic [W-1:0]                                    p,
    input  logic [W-1:0]                                    g,
    input  logic                                            cin,
    output logic [hsa_pkg::group_count(W, GRP_W)-1:0]       grp_cin,
    output logic [hsa_pkg::group_count(W, GRP_W)-1:0]       grp_cout
);

    localparam int NGRP = hsa_pkg::group_count(W, GRP_W);

    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;

    // Group generate / propagate for every group.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO = k * GRP_W;
        localparam int GW = hsa_pkg::group_width(k, W, GRP_W);
        logic gen_acc;
        logic prp_acc;
        always_comb begin
            gen_acc = 1'b0;
            prp_acc = 1'b1;
            for (int i = 0; i < GW; i++) begin
                gen_acc = g[LO+i] | (p[LO+i] & gen_acc);
                prp_acc = prp_acc & p[LO+i];
            end
        end
        assign grp_g[k] = gen_acc;
        assign grp_p[k] = prp_acc;
    end

    // Carry chain across group boundaries: c(k+1) = G(k) + P(k)*c(k).
    always_comb begin
        logic c;
        c = cin;
        for (int k = 0; k < NGRP; k++) begin
            grp_cin[k]  = c;
            c           = grp_g[k] | (grp_p[k] & c);
            grp_cout[k] = c;
        end
    end

endmodule

// File: rtl/hsa_skip_group.sv
module hsa_skip_group #(
    parameter int MW = 16,
    parameter int SW = 4
) (
    input  logic [MW-1:0]    p,
    input  logic [MW-1:0]    g,
    input  logic             grp_cin,
    output logic [MW-1:0]    s,
    output logic             rip_cout,
    output logic [MW/SW-1:0] sub_cin,
    output logic [MW/SW-1:0] skip_n
);

    localparam int NS = MW / SW;

    for (genvar j = 0; j < NS; j++) begin : g_sub
        localparam int LO = j * SW;
        logic          ci;
        logic          co;
        logic [SW-1:0] s_loc;

        if (j == 0) begin : g_first
            // Lowest sub-block: group carry-in taken directly, no mux.
            assign skip_n[j] = 1'b1;
            assign ci        = grp_cin;
        end else begin : g_upper
            // Active-low skip: every bit below in this group propagates.
            assign skip_n[j] = ~(&p[LO-1:0]);
            assign ci        = skip_n[j] ? g_sub[j-1].co : grp_cin;
        end

        always_comb begin
            logic c;
            c = ci;
            for (int i = 0; i < SW; i++) begin
                s_loc[i] = p[LO+i] ^ c;
                c        = g[LO+i] | (p[LO+i] & c);
            end
            co = c;
        end

        assign s[LO +: SW] = s_loc;
        assign sub_cin[j]  = ci;
    end

    assign rip_cout = g_sub[NS-1].co;

endmodule

// File: rtl/hybrid_skip_adder.sv
module hybrid_skip_adder #(
    parameter int WIDTH   = 56,
    parameter int MOD_W   = 16,
    parameter int SUB_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    // WIDTH and MOD_W are expected to be multiples of SUB_W.
    localparam int NMOD = hsa_pkg::group_count(WIDTH, MOD_W);
    localparam int NSUB = WIDTH / SUB_W;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    logic [WIDTH-1:0] p;
    logic [WIDTH-1:0] g;
    logic [WIDTH-1:0] comb_sum;
    logic             comb_cout;
    logic [NMOD-1:0]  mod_cin;
    logic [NMOD-1:0]  grp_cout;
    logic [NMOD-1:0]  rip_cout;
    logic [NSUB-1:0]  sub_cin;
    logic [NSUB-1:0]  skip_n;

    hsa_pg_gen #(.W(WIDTH)) u_pg (
        .a (a),
        .b (b),
        .p (p),
        .g (g)
    );

    hsa_lookahead #(.W(WIDTH), .GRP_W(MOD_W)) u_la (
        .p        (p),
        .g        (g),
        .cin      (cin),
        .grp_cin  (mod_cin),
        .grp_cout (grp_cout)
    );

    for (genvar k = 0; k < NMOD; k++) begin : g_mod
        localparam int LO = k * MOD_W;
        localparam int GW = hsa_pkg::group_width(k, WIDTH, MOD_W);
        hsa_skip_group #(.MW(GW), .SW(SUB_W)) u_grp (
            .p        (p[LO +: GW]),
            .g        (g[LO +: GW]),
            .grp_cin  (mod_cin[k]),
            .s        (comb_sum[LO +: GW]),
            .rip_cout (rip_cout[k]),
            .sub_cin  (sub_cin[LO/SUB_W +: GW/SUB_W]),
            .skip_n   (skip_n[LO/SUB_W +: GW/SUB_W])
        );
    end

    assign comb_cout = grp_cout[NMOD-1];

    if (REG_OUT) begin : g_reg
        res_t res_d;
        res_t res_q;

        always_comb begin
            res_d      = res_q;
            res_d.sum  = comb_sum;
            res_d.cout = comb_cout;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        assign sum  = res_q.sum;
        assign cout = res_q.cout;
    end else begin : g_comb
        assign sum  = comb_sum;
        assign cout = comb_cout;
    end

endmodule

// File: rtl/hsa_checker.sv
module hsa_checker #(
    parameter int WIDTH   = 56,
    parameter int MOD_W   = 16,
    parameter int SUB_W   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic [WIDTH-1:0]                             a,
    input logic [WIDTH-1:0]                             b,
    input logic                                         cin,
    input logic [WIDTH-1:0]                             comb_sum,
    input logic                                         comb_cout,
    input logic [WIDTH-1:0]                             sum,
    input logic                                         cout,
    input logic [hsa_pkg::group_count(WIDTH, MOD_W)-1:0] mod_cin,
    input logic [hsa_pkg::group_count(WIDTH, MOD_W)-1:0] rip_cout,
    input logic [WIDTH/SUB_W-1:0]                       sub_cin,
    input logic [WIDTH/SUB_W-1:0]                       skip_n
);

    localparam int NMOD = hsa_pkg::group_count(WIDTH, MOD_W);
    localparam int NSUB = WIDTH / SUB_W;
    localparam int SPM  = MOD_W / SUB_W;

    function automatic logic carry_into(input logic [WIDTH-1:0] x,
                                        input logic [WIDTH-1:0] y,
                                        input logic ci, input int pos);
        logic [WIDTH:0] mask;
        logic [WIDTH:0] t;
        mask = ({{WIDTH{1'b0}}, 1'b1} << pos) - 1'b1;
        t    = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {{WIDTH{1'b0}}, ci};
        return t[pos];
    endfunction

    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        {comb_cout, comb_sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));

    for (genvar k = 0; k < NMOD; k++) begin : g_mod_chk
        p_mod_cin_r2: assert property (@(posedge clk) disable iff (!rst_n)
            mod_cin[k] == carry_into(a, b, cin, k * MOD_W));
        if (k + 1 < NMOD) begin : g_mid
            p_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
                rip_cout[k] == mod_cin[k+1]);
        end else begin : g_top
            p_boundary_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
                rip_cout[k] == comb_cout);
        end
    end

    for (genvar j = 0; j < NSUB; j++) begin : g_sub_chk
        p_skip_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !skip_n[j] |-> (sub_cin[j] == mod_cin[j / SPM]));
        p_sub_cin_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sub_cin[j] == carry_into(a, b, cin, j * SUB_W));
    end

    if (REG_OUT) begin : g_reg_chk
        logic armed_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed_q <= 1'b0;
            else        armed_q <= 1'b1;
        end
        p_out_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> ({cout, sum} == $past({comb_cout, comb_sum})));
    end

endmodule

bind hybrid_skip_adder hsa_checker #(
    .WIDTH(WIDTH), .MOD_W(MOD_W), .SUB_W(SUB_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (a),
    .b         (b),
    .cin       (cin),
    .comb_sum  (comb_sum),
    .comb_cout (comb_cout),
    .sum       (sum),
    .cout      (cout),
    .mod_cin   (mod_cin),
    .rip_cout  (rip_cout),
    .sub_cin   (sub_cin),
    .skip_n    (skip_n)
);

// File: tb/hybrid_skip_adder_test.sv
`timescale 1ns/1ps
module hybrid_skip_adder_test;

    localparam int W = 56;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hybrid_skip_adder uut (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic ci);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    endfunction

    function automatic logic [W-1:0] rnd56();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[W-1:0];
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic apply(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic ci);
        @(negedge clk);
        a = x; b = y; cin = ci;
        @(negedge clk);
        check(tag, {cout, sum}, ref_add(x, y, ci));
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // R7: held at zero in reset even with live inputs.
        a = ONES; b = 56'd1; cin = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 reset hold", {cout, sum}, '0);
        rst_n = 1'b1;

        // R8: all-propagate, both carry-in values.
        apply("R8 all-propagate cin0", 56'hAA_AAAA_AAAA_AAAA, 56'h55_5555_5555_5555, 1'b0);
        apply("R8 all-propagate cin1", 56'hAA_AAAA_AAAA_AAAA, 56'h55_5555_5555_5555, 1'b1);
        apply("R8 R3 propagate ones+0 cin1", ONES, '0, 1'b1);
        // R9: all-generate.
        apply("R9 all-generate cin0", ONES, ONES, 1'b0);
        apply("R9 all-generate cin1", ONES, ONES, 1'b1);
        // R1: alternating patterns.
        apply("R1 alternating same", 56'hAA_AAAA_AAAA_AAAA, 56'hAA_AAAA_AAAA_AAAA, 1'b0);
        apply("R1 alternating 55", 56'h55_5555_5555_5555, 56'h55_5555_5555_5555, 1'b1);
        apply("R1 zeros", '0, '0, 1'b0);

        // R2 + R3: generate at bit 15, skip over everything above.
        apply("R2 R3 gen15 through skip", {{40{1'b1}}, 16'h8000}, 56'h00_0000_0000_8000, 1'b0);
        apply("R2 gen31 through skip", {{24{1'b1}}, 32'h8000_0000}, 56'h00_0000_8000_0000, 1'b0);

        // R4 + R5: carry run ending at every sub-block and group boundary.
        for (int pos = 4; pos <= W; pos += 4) begin
            logic [W-1:0] run;
            run = (pos == W) ? ONES : ((56'd1 << pos) - 56'd1);
            apply((pos % 16 == 0) ? "R5 R4 group boundary run" : "R4 sub-block boundary run",
                  run, 56'd1, 1'b0);
            apply("R4 run via cin", run, '0, 1'b1);
        end

        // R6: output holds between edges and follows one edge later.
        @(negedge clk);
        a = 56'h12_3456_789A_BCDE; b = 56'h0F_0F0F_0F0F_0F0F; cin = 1'b1;
        @(negedge clk);
        a = 56'h01; b = 56'h02; cin = 1'b0;
        #2;
        check("R6 hold before edge", {cout, sum},
              ref_add(56'h12_3456_789A_BCDE, 56'h0F_0F0F_0F0F_0F0F, 1'b1));
        @(negedge clk);
        check("R6 next edge", {cout, sum}, ref_add(56'h01, 56'h02, 1'b0));

        // R1: plain random operands.
        for (int n = 0; n < 3000; n++) begin
            apply("R1 random", rnd56(), rnd56(), 1'($urandom() & 1));
        end

        // R3 R4: long propagate runs with sparse breaks.
        for (int n = 0; n < 1000; n++) begin
            logic [W-1:0] x;
            logic [W-1:0] brk;
            x   = rnd56();
            brk = (56'd1 << ($urandom() % W));
            apply("R3 R4 long propagate", x, ~x ^ brk, 1'($urandom() & 1));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule